// File: doc/BRIEF.md
# Folded Bitonic Sorter with Sequencer

This block sorts a list of tagged measurements: each entry pairs an unsigned voltage sample with a small position tag. It does not build a full bitonic network. It keeps the entries in a register file and reuses a small set of compare-and-swap cells across the whole comparison schedule. A sequencer walks that schedule one step per clock. Each step applies every cell once to a disjoint pair of register entries. The schedule is produced by counters, so no schedule table is stored.

A caller presents the whole list, with the number of real entries, on the input buses and pulses `start` while the block is idle. Slots at or beyond that count are turned into filler entries with voltage zero and an all-ones tag. The order rules place these fillers after every real entry. `busy` stays high from the cycle after the start until the block is idle again, and a start seen during that time is dropped. `done` marks the single cycle after the last step. The sorted list then stays on the output buses until the next accepted start. The number of cells is a parameter, which sets how much logic the block uses and how long a sort takes.

Top module: `bitonic_fold_sorter`

## Requirements
- R1: During and after reset, `busy` and `done` are 0 and every output slot holds a filler entry (voltage 0, tag all ones).
- R2: A `start` sampled high while idle captures `inVolt`, `inTag` and `listLen` at that edge, and `busy` reads 1 after it.
- R3: In the result, slot 0 holds the highest-ranked entry. Rank is by higher voltage first and, at equal voltage, by smaller tag first. Each tag stays paired with its voltage.
- R4: Input slots with index not below the captured length become filler entries (voltage 0, tag all ones) and end up after every real entry, including real entries of voltage 0.
- R5: A `listLen` above NUM_ENTRIES is handled as NUM_ENTRIES.
- R6: Counting the accepted start edge as edge 1, `done` first reads 1 after edge 2 + L(L+1)/2 · NUM_ENTRIES/(2·CAS_CELLS), with L = log2(NUM_ENTRIES). This is edge 26 for the defaults.
- R7: `done` is high for exactly one cycle, and `busy` is 0 in the cycle after it.
- R8: A `start` seen while `busy` is 1, including the `done` cycle, is ignored: the result and the timing of the running sort are unchanged, and no new sort begins.
- R9: The sorted list stays unchanged on the outputs while the block is idle, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sort; acted on only while idle |
| listLen | input | $clog2(NUM_ENTRIES+1) | Number of real entries in the input list |
| inVolt | input | NUM_ENTRIES*VOLT_W | Input voltages, slot e at bits [e*VOLT_W +: VOLT_W] |
| inTag | input | NUM_ENTRIES*TAG_W | Input tags, slot e at bits [e*TAG_W +: TAG_W] |
| busy | output | 1 | High while a sort is loading, running or finishing |
| done | output | 1 | One-cycle pulse: the sorted list is ready |
| outVolt | output | NUM_ENTRIES*VOLT_W | Sorted voltages, slot 0 highest ranked |
| outTag | output | NUM_ENTRIES*TAG_W | Tags paired with `outVolt` |

## Verification
On every cycle, the assertions check three things: the load, pad and compare strobes never overlap, each accepted start is followed by exactly the scheduled number of compare steps, and `done` lasts one cycle. Whenever `done` is high, they also check that adjacent output slots are in rank order and that no real entry follows a filler. Only the bench scenarios can show that the output is the right permutation of the captured list with tags kept in pairs. They also show the exact latency seen at the ports, the clamping of an oversize length, and that starts arriving mid-sort or in the `done` cycle leave the result alone.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int LOGF_W = 5;
  localparam int GRP_W  = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SORT, ST_DONE} seqState_t;

  typedef struct packed {
    logic              capture;
    logic              pad;
    logic              step;
    logic [LOGF_W-1:0] stageLog;
    logic [LOGF_W-1:0] passLog;
    logic [GRP_W-1:0]  group;
  } seqCmd_t;
endpackage

// File: rtl/bfs_ctrl.sv
module bfs_ctrl
  import bfs_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int CAS_CELLS   = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output seqCmd_t cmd,
  output logic    busy,
  output logic    done
);
  localparam int LOG    = $clog2(NUM_ENTRIES);
  localparam int GROUPS = NUM_ENTRIES / (2 * CAS_CELLS);
  localparam int TOTAL  = (LOG * (LOG + 1) / 2) * GROUPS;

  seqState_t         state;
  logic [LOGF_W-1:0] stageLog, passLog;
  logic [GRP_W-1:0]  group;
  logic              lastGroup, lastPass, lastStage;

  assign lastGroup = (group == GRP_W'(GROUPS - 1));
  assign lastPass  = (passLog == '0);
  assign lastStage = (stageLog == LOGF_W'(LOG));

  always_comb begin
    cmd          = '0;
    cmd.capture  = (state == ST_IDLE) && start;
    cmd.pad      = (state == ST_LOAD);
    cmd.step     = (state == ST_SORT);
    cmd.stageLog = stageLog;
    cmd.passLog  = passLog;
    cmd.group    = group;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stageLog <= '0;
      passLog  <= '0;
      group    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_LOAD;
          stageLog <= LOGF_W'(1);
          passLog  <= '0;
          group    <= '0;
        end
        ST_LOAD: state <= ST_SORT;
        ST_SORT: begin
          if (!lastGroup) begin
            group <= group + 1'b1;
          end else begin
            group <= '0;
            if (!lastPass) begin
              passLog <= passLog - 1'b1;
            end else if (!lastStage) begin
              stageLog <= stageLog + 1'b1;
              passLog  <= stageLog;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checker counter: compare steps since the last capture
  int stepCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            stepCnt <= 0;
    else if (cmd.capture) stepCnt <= 0;
    else if (cmd.step)    stepCnt <= stepCnt + 1;
  end

  // R6
  step_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (stepCnt == TOTAL));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/bfs_cas_cell.sv
module bfs_cas_cell #(
  parameter int VOLT_W = 12,
  parameter int TAG_W  = 4
) (
  input  logic [VOLT_W-1:0] aVolt,
  input  logic [TAG_W-1:0]  aTag,
  input  logic [VOLT_W-1:0] bVolt,
  input  logic [TAG_W-1:0]  bTag,
  input  logic              upFirst,
  output logic [VOLT_W-1:0] loVolt,
  output logic [TAG_W-1:0]  loTag,
  output logic [VOLT_W-1:0] hiVolt,
  output logic [TAG_W-1:0]  hiTag
);
  logic aRanks, swap;

  // rank key: voltage, then inverted tag (smaller tag wins, filler loses ties)
  assign aRanks = {aVolt, ~aTag} > {bVolt, ~bTag};
  assign swap   = upFirst ? !aRanks : aRanks;

  assign loVolt = swap ? bVolt : aVolt;
  assign loTag  = swap ? bTag  : aTag;
  assign hiVolt = swap ? aVolt : bVolt;
  assign hiTag  = swap ? aTag  : bTag;
endmodule

// File: rtl/bfs_datapath.sv
module bfs_datapath
  import bfs_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int CAS_CELLS   = 1,
  parameter int VOLT_W      = 12,
  parameter int TAG_W       = 4,
  parameter int LEN_W       = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqCmd_t                       cmd,
  input  logic [LEN_W-1:0]              listLen,
  input  logic [NUM_ENTRIES*VOLT_W-1:0] inVolt,
  input  logic [NUM_ENTRIES*TAG_W-1:0]  inTag,
  output logic [NUM_ENTRIES*VOLT_W-1:0] outVolt,
  output logic [NUM_ENTRIES*TAG_W-1:0]  outTag
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  logic [VOLT_W-1:0] voltReg [NUM_ENTRIES];
  logic [TAG_W-1:0]  tagReg  [NUM_ENTRIES];
  logic [LEN_W-1:0]  lenReg;

  logic [IDX_W-1:0]  loIdx   [CAS_CELLS];
  logic [IDX_W-1:0]  hiIdx   [CAS_CELLS];
  logic              upFirst [CAS_CELLS];
  logic [VOLT_W-1:0] wrLoV   [CAS_CELLS];
  logic [VOLT_W-1:0] wrHiV   [CAS_CELLS];
  logic [TAG_W-1:0]  wrLoT   [CAS_CELLS];
  logic [TAG_W-1:0]  wrHiT   [CAS_CELLS];

  // pair selection: insert a zero bit at the pass distance into the comparison number
  always_comb begin
    for (int q = 0; q < CAS_CELLS; q++) begin
      int c, s, lo;
      c  = int'(cmd.group) * CAS_CELLS + q;
      s  = int'(cmd.passLog);
      lo = ((c >> s) << (s + 1)) | (c & ((1 << s) - 1));
      loIdx[q]   = IDX_W'(lo);
      hiIdx[q]   = IDX_W'(lo | (1 << s));
      upFirst[q] = ((lo >> int'(cmd.stageLog)) & 1) == 0;
    end
  end

  for (genvar q = 0; q < CAS_CELLS; q++) begin : g_cell
    bfs_cas_cell #(.VOLT_W(VOLT_W), .TAG_W(TAG_W)) i_cell (
      .aVolt  (voltReg[loIdx[q]]),
      .aTag   (tagReg[loIdx[q]]),
      .bVolt  (voltReg[hiIdx[q]]),
      .bTag   (tagReg[hiIdx[q]]),
      .upFirst(upFirst[q]),
      .loVolt (wrLoV[q]),
      .loTag  (wrLoT[q]),
      .hiVolt (wrHiV[q]),
      .hiTag  (wrHiT[q])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg <= '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        voltReg[e] <= '0;
        tagReg[e]  <= '1;
      end
    end else if (cmd.capture) begin
      lenReg <= (listLen > LEN_W'(NUM_ENTRIES)) ? LEN_W'(NUM_ENTRIES) : listLen;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        voltReg[e] <= inVolt[e*VOLT_W +: VOLT_W];
        tagReg[e]  <= inTag[e*TAG_W +: TAG_W];
      end
    end else if (cmd.pad) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (LEN_W'(e) >= lenReg) begin
          voltReg[e] <= '0;
          tagReg[e]  <= '1;
        end
      end
    end else if (cmd.step) begin
      for (int q = 0; q < CAS_CELLS; q++) begin
        voltReg[loIdx[q]] <= wrLoV[q];
        tagReg[loIdx[q]]  <= wrLoT[q];
        voltReg[hiIdx[q]] <= wrHiV[q];
        tagReg[hiIdx[q]]  <= wrHiT[q];
      end
    end
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_out
    assign outVolt[e*VOLT_W +: VOLT_W] = voltReg[e];
    assign outTag[e*TAG_W +: TAG_W]    = tagReg[e];
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.capture, cmd.pad, cmd.step}));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.capture || cmd.pad || cmd.step) |=> ($stable(outVolt) && $stable(outTag)));
endmodule

// File: rtl/bitonic_fold_sorter.sv
module bitonic_fold_sorter
  import bfs_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VOLT_W      = 12,
  parameter int TAG_W       = 4,
  parameter int CAS_CELLS   = 1,
  localparam int LEN_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [LEN_W-1:0]              listLen,
  input  logic [NUM_ENTRIES*VOLT_W-1:0] inVolt,
  input  logic [NUM_ENTRIES*TAG_W-1:0]  inTag,
  output logic                          busy,
  output logic                          done,
  output logic [NUM_ENTRIES*VOLT_W-1:0] outVolt,
  output logic [NUM_ENTRIES*TAG_W-1:0]  outTag
);
  seqCmd_t cmd;

  bfs_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .CAS_CELLS(CAS_CELLS)) i_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .cmd  (cmd),
    .busy (busy),
    .done (done)
  );

  bfs_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .CAS_CELLS(CAS_CELLS),
    .VOLT_W(VOLT_W), .TAG_W(TAG_W), .LEN_W(LEN_W)
  ) i_data (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .listLen(listLen),
    .inVolt (inVolt),
    .inTag  (inTag),
    .outVolt(outVolt),
    .outTag (outTag)
  );

  for (genvar e = 0; e < NUM_ENTRIES - 1; e++) begin : g_ord
    // R3
    rank_order_chk: assert property (@(posedge clk) disable iff (!rstN)
      done |-> ({outVolt[e*VOLT_W +: VOLT_W], ~outTag[e*TAG_W +: TAG_W]} >=
                {outVolt[(e+1)*VOLT_W +: VOLT_W], ~outTag[(e+1)*TAG_W +: TAG_W]}));
    // R4
    filler_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
      (done && outTag[e*TAG_W +: TAG_W] == '1 && outVolt[e*VOLT_W +: VOLT_W] == '0)
        |-> (outTag[(e+1)*TAG_W +: TAG_W] == '1 && outVolt[(e+1)*VOLT_W +: VOLT_W] == '0));
  end
endmodule

// File: tb/test_bitonic_fold_sorter.sv
module test_bitonic_fold_sorter;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int VW  = 12;
  localparam int TW  = 4;
  localparam int LW  = 4;
  localparam int LAT = 26;
  localparam int VEC_CNT = 7;

  localparam logic [N*VW-1:0] VEC_VOLT [VEC_CNT] = '{
    {12'd4095, 12'd42, 12'd900, 12'd900, 12'd77, 12'd5, 12'd1200, 12'd300},
    {12'd8, 12'd7, 12'd6, 12'd5, 12'd4, 12'd3, 12'd2, 12'd1},
    {12'd500, 12'd500, 12'd500, 12'd500, 12'd500, 12'd500, 12'd500, 12'd500},
    {12'd999, 12'd999, 12'd999, 12'd999, 12'd999, 12'd20, 12'd0, 12'd10},
    {12'd1234, 12'd1234, 12'd1234, 12'd1234, 12'd1234, 12'd1234, 12'd1234, 12'd1234},
    {12'd0, 12'd500, 12'd1000, 12'd1500, 12'd2000, 12'd2500, 12'd3000, 12'd4000},
    {12'd55, 12'd55, 12'd55, 12'd7, 12'd4095, 12'd0, 12'd4095, 12'd0}
  };
  localparam int VEC_LEN [VEC_CNT] = '{8, 8, 8, 3, 0, 15, 5};
  localparam string VEC_REQ [VEC_CNT] = '{"R3", "R3", "R3", "R4", "R4", "R5", "R4"};

  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  logic [LW-1:0] listLen = '0;
  logic [N*VW-1:0] inVolt = '0;
  logic [N*TW-1:0] inTag = '0;
  logic busy, done;
  logic [N*VW-1:0] outVolt;
  logic [N*TW-1:0] outTag;

  int checkCnt = 0;
  int failCnt = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitonic_fold_sorter #(.NUM_ENTRIES(N), .VOLT_W(VW), .TAG_W(TW), .CAS_CELLS(1)) i_bitonic_fold_sorter (
    .clk(clk), .rstN(rstN), .start(start), .listLen(listLen),
    .inVolt(inVolt), .inTag(inTag), .busy(busy), .done(done),
    .outVolt(outVolt), .outTag(outTag)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failCnt++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [N*TW-1:0] makeTags(input int off);
    logic [N*TW-1:0] t;
    for (int e = 0; e < N; e++) t[e*TW +: TW] = TW'((e + off) % N);
    return t;
  endfunction

  // independent reference: fill, then selection sort on (voltage desc, tag asc)
  task automatic refSort(input logic [N*VW-1:0] v, input logic [N*TW-1:0] t, input int len,
                         output logic [N*VW-1:0] ev, output logic [N*TW-1:0] et);
    logic [VW-1:0] kv [N];
    logic [TW-1:0] kt [N];
    int useLen;
    useLen = (len > N) ? N : len;
    for (int e = 0; e < N; e++) begin
      kv[e] = (e < useLen) ? v[e*VW +: VW] : '0;
      kt[e] = (e < useLen) ? t[e*TW +: TW] : '1;
    end
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (kv[j] > kv[i] || (kv[j] == kv[i] && kt[j] < kt[i])) begin
          logic [VW-1:0] sv;
          logic [TW-1:0] st;
          sv = kv[i]; kv[i] = kv[j]; kv[j] = sv;
          st = kt[i]; kt[i] = kt[j]; kt[j] = st;
        end
      end
    end
    for (int e = 0; e < N; e++) begin
      ev[e*VW +: VW] = kv[e];
      et[e*TW +: TW] = kt[e];
    end
  endtask

  // drive one sort; optional starts during busy and in the done cycle
  task automatic runSort(input logic [N*VW-1:0] v, input logic [N*TW-1:0] t, input int len,
                         input string req, input bit disturb);
    logic [N*VW-1:0] ev;
    logic [N*TW-1:0] et;
    int cycles;
    refSort(v, t, len, ev, et);
    @(negedge clk);
    inVolt = v; inTag = t; listLen = LW'(len); start = 1;
    @(posedge clk);
    cycles = 1;
    #1;
    start = 0;
    check(busy == 1'b1, "R2", "busy after start", 128'(busy), 128'(1));
    while (!done && cycles < 1000) begin
      if (disturb && cycles >= 5 && cycles < 8) begin
        inVolt = ~v; inTag = makeTags(3); listLen = LW'(8); start = 1;
      end else begin
        start = 0;
      end
      @(posedge clk);
      cycles++;
      #1;
    end
    start = 0;
    check(cycles == LAT, disturb ? "R8" : "R6", "latency", 128'(cycles), 128'(LAT));
    check(outVolt == ev, req, "sorted voltages", 128'(outVolt), 128'(ev));
    check(outTag == et, req, "sorted tags", 128'(outTag), 128'(et));
    if (disturb) begin
      inVolt = ~v; inTag = makeTags(5); listLen = LW'(8); start = 1;
    end
    @(posedge clk);
    #1;
    start = 0;
    check(done == 1'b0, "R7", "done after one cycle", 128'(done), 128'(0));
    check(busy == 1'b0, disturb ? "R8" : "R7", "busy after done", 128'(busy), 128'(0));
    repeat (3) @(posedge clk);
    #1;
    check(busy == 1'b0, disturb ? "R8" : "R9", "still idle", 128'(busy), 128'(0));
    check(outVolt == ev && outTag == et, "R9", "result held while idle",
          128'({outTag, outVolt}), 128'({et, ev}));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values while reset is held
    check(busy == 1'b0, "R1", "busy in reset", 128'(busy), 128'(0));
    check(done == 1'b0, "R1", "done in reset", 128'(done), 128'(0));
    check(outVolt == '0, "R1", "voltages in reset", 128'(outVolt), 128'(0));
    check(outTag == '1, "R1", "tags in reset", 128'(outTag), 128'({N*TW{1'b1}}));
    @(negedge clk);
    rstN = 1;
    @(posedge clk);
    #1;
    check(busy == 1'b0 && outTag == '1, "R1", "idle after reset",
          128'({busy, outTag}), 128'({1'b0, {N*TW{1'b1}}}));

    for (int k = 0; k < VEC_CNT; k++) begin
      runSort(VEC_VOLT[k], makeTags(k), VEC_LEN[k], VEC_REQ[k], 1'b0);
    end

    // R8: starts while busy and in the done cycle are dropped
    runSort(VEC_VOLT[0], makeTags(2), 8, "R8", 1'b1);

    // R2: a fresh start after the dropped ones is accepted with new data
    runSort(VEC_VOLT[6], makeTags(1), 8, "R2", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule